// File: doc/BRIEF.md
# Bitwise Logic Unit with Status Flags

This block is the bitwise logic stage of a small processor datapath. It receives an operation code and two resolved operand values, a destination and a source. It forms the AND, OR or XOR of the two, or the one's complement of the destination. A test operation forms the AND but does not write anything back. The result is combinational, so it is valid in the same cycle as the inputs. A write-enable output tells the register file or memory stage whether the result should be stored.

The unit also holds a six-bit registered flag file. When an input is strobed valid, the flag file is updated according to the operation. AND, OR, XOR and test derive sign, zero and parity from the result, clear carry and overflow, and keep the auxiliary-carry flag. Complement leaves every flag as it was. Operands are either a full word or a single byte. In byte mode the upper part of the destination passes through untouched and is ignored by the flags.

Top module: `bitlogic_unit`

## Requirements
- R1: With op code 0 the result is dst AND src, with 1 it is dst OR src, with 2 it is dst XOR src, and with 3 it is NOT dst; the result appears combinationally in the same cycle as the inputs.
- R2: Op code 4 (test) yields dst AND src on the result port and holds dst_we low.
- R3: dst_we is high only when in_valid is high and the op code is 0, 1, 2 or 3.
- R4: After a valid op with code 0, 1, 2 or 4, carry (flags bit 2) and overflow (flags bit 1) read 0.
- R5: After such an op, sign (flags bit 5) equals result bit 7 in byte mode and result bit 15 in word mode.
- R6: After such an op, zero (flags bit 4) is 1 exactly when all result bits within the selected width are 0.
- R7: After such an op, parity (flags bit 3) is 1 exactly when result bits 7..0 hold an even number of ones, in either width.
- R8: Auxiliary carry (flags bit 0) keeps its previous value across ops with code 0, 1, 2 and 4.
- R9: A valid op with code 3 leaves all six flag bits unchanged.
- R10: The flags change only on a rising clock edge with in_valid high; with in_valid low they hold, and dst_we is low.
- R11: With byte_mode high, result bits 15..8 equal dst bits 15..8 for every op code, and dst bits 15..8 do not affect any flag.
- R12: While rst_n is low at a rising edge, all flag bits are cleared to 0.
- R13: Op codes 5, 6 and 7 give result equal to dst, hold dst_we low, and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flag file |
| in_valid | input | 1 | Strobe marking the current inputs as an operation |
| op_sel | input | 3 | Operation code: 0 AND, 1 OR, 2 XOR, 3 NOT, 4 test |
| byte_mode | input | 1 | 1 selects 8-bit operands, 0 selects 16-bit operands |
| dst_val | input | 16 | Destination operand |
| src_val | input | 16 | Source operand |
| result | output | 16 | Combinational operation result |
| dst_we | output | 1 | Destination write-enable |
| flags_q | output | 6 | Registered flags: bit 5 sign, 4 zero, 3 parity, 2 carry, 1 overflow, 0 auxiliary carry |

## Verification
Two things happen in the same cycle of every valid operation: the combinational result and write-enable are produced, and the flag file commits a new value at the closing edge. The bench drives each operation at the falling edge and samples just after the next rising edge. At that point the inputs, and so the result, still belong to the operation while the flags already reflect it. A single scoreboard item therefore judges both together. Test followed by complement, and byte operations with a non-zero upper destination byte, are placed back to back. This shows that write suppression, flag hold and the byte-mode pass-through do not interfere with the flag update of the same cycle.

// File: rtl/bitlogic_pkg.sv
// Package: shared operation codes and flag layout for the bitwise logic unit.
// Assumes: consumers use op codes exactly as listed; codes above OP_TEST are undefined.
package bitlogic_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_NOT  = 3'd3,
        OP_TEST = 3'd4
    } bl_op_e;

    // Flag file layout, most significant field first (bit 5 .. bit 0).
    typedef struct packed {
        logic sign;
        logic zero;
        logic parity;
        logic carry;
        logic ovf;
        logic aux;
    } bl_flags_t;

    localparam int FLAG_W = 6;

endpackage

// File: rtl/bitlogic_result_path.sv
// Module: computes the bitwise result and the destination write-enable.
// Assumes: WORD_W is a whole multiple of BYTE_W; in byte mode only lane 0 is
// operated on and every higher lane passes the destination through.
module bitlogic_result_path #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [2:0]        op_sel,
    input  logic              byte_mode,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] dst_val,
    input  logic [WORD_W-1:0] src_val,
    output logic [WORD_W-1:0] result,
    output logic              dst_we
);
    import bitlogic_pkg::*;

    localparam int LANES = WORD_W / BYTE_W;

    logic [WORD_W-1:0] full_res;

    // Full-width bitwise operation selected by the op code.
    always_comb begin
        case (op_sel)
            OP_AND, OP_TEST: full_res = dst_val & src_val;
            OP_OR:           full_res = dst_val | src_val;
            OP_XOR:          full_res = dst_val ^ src_val;
            OP_NOT:          full_res = ~dst_val;
            default:         full_res = dst_val;
        endcase
    end

    // Lane steering: lane 0 always takes the operation, upper lanes only in word mode.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        if (ln == 0) begin : g_low
            assign result[BYTE_W-1:0] = full_res[BYTE_W-1:0];
        end else begin : g_high
            assign result[ln*BYTE_W +: BYTE_W] = byte_mode ? dst_val[ln*BYTE_W +: BYTE_W]
                                                           : full_res[ln*BYTE_W +: BYTE_W];
        end
    end

    // Write-enable: stores for the four writing operations, never for test or undefined codes.
    always_comb begin
        case (op_sel)
            OP_AND, OP_OR, OP_XOR, OP_NOT: dst_we = in_valid;
            default:                       dst_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/bitlogic_flag_eval.sv
// Module: derives the next flag value and the update strobe from the result.
// Assumes: result is the steered output of the result path; parity always
// looks at the low byte only, sign and zero follow the selected width.
module bitlogic_flag_eval #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [2:0]                op_sel,
    input  logic                      byte_mode,
    input  logic                      in_valid,
    input  logic [WORD_W-1:0]         result,
    input  bitlogic_pkg::bl_flags_t   cur_flags,
    output bitlogic_pkg::bl_flags_t   nxt_flags,
    output logic                      flag_upd
);
    import bitlogic_pkg::*;

    logic sign_bit;
    logic zero_bit;
    logic par_bit;

    // Width-dependent sign and zero, low-byte even parity.
    always_comb begin
        sign_bit = byte_mode ? result[BYTE_W-1] : result[WORD_W-1];
        zero_bit = byte_mode ? ~|result[BYTE_W-1:0] : ~|result;
        par_bit  = ~^result[BYTE_W-1:0];
    end

    // Update strobe: only flag-writing operations with a valid input.
    always_comb begin
        case (op_sel)
            OP_AND, OP_OR, OP_XOR, OP_TEST: flag_upd = in_valid;
            default:                        flag_upd = 1'b0;
        endcase
    end

    // Next flag word: carry and overflow forced low, auxiliary carry kept.
    always_comb begin
        nxt_flags.sign   = sign_bit;
        nxt_flags.zero   = zero_bit;
        nxt_flags.parity = par_bit;
        nxt_flags.carry  = 1'b0;
        nxt_flags.ovf    = 1'b0;
        nxt_flags.aux    = cur_flags.aux;
    end

endmodule

// File: rtl/bitlogic_flag_file.sv
// Module: registered flag storage with synchronous active-low reset.
// Assumes: upd is a single-cycle qualified strobe from the flag evaluator.
module bitlogic_flag_file (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  bitlogic_pkg::bl_flags_t nxt,
    output bitlogic_pkg::bl_flags_t q
);
    // Flag register: clear on reset, load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (upd) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/bitlogic_unit.sv
// Module: top of the bitwise logic unit; result path, flag evaluator, flag file.
// Assumes: operands arrive already fetched; result and dst_we are combinational,
// flags_q is the registered flag file visible from the cycle after an update.
module bitlogic_unit #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic              byte_mode,
    input  logic [WORD_W-1:0] dst_val,
    input  logic [WORD_W-1:0] src_val,
    output logic [WORD_W-1:0] result,
    output logic              dst_we,
    output logic [5:0]        flags_q
);
    import bitlogic_pkg::*;

    bl_flags_t flag_cur;
    bl_flags_t flag_nxt;
    logic      flag_upd;

    bitlogic_result_path #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_res (
        .op_sel    (op_sel),
        .byte_mode (byte_mode),
        .in_valid  (in_valid),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .result    (result),
        .dst_we    (dst_we)
    );

    bitlogic_flag_eval #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_eval (
        .op_sel    (op_sel),
        .byte_mode (byte_mode),
        .in_valid  (in_valid),
        .result    (result),
        .cur_flags (flag_cur),
        .nxt_flags (flag_nxt),
        .flag_upd  (flag_upd)
    );

    bitlogic_flag_file u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (flag_upd),
        .nxt   (flag_nxt),
        .q     (flag_cur)
    );

    assign flags_q = flag_cur;

endmodule

// File: rtl/bitlogic_unit_chk.sv
// Checker: temporal properties of the bitwise logic unit, bound to its top.
// Assumes: flag bit map 5 sign, 4 zero, 3 parity, 2 carry, 1 overflow, 0 aux.
module bitlogic_unit_chk #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic              byte_mode,
    input logic [WORD_W-1:0] dst_val,
    input logic [WORD_W-1:0] result,
    input logic              dst_we,
    input logic [5:0]        flags_q
);
    logic flag_op;
    assign flag_op = (op_sel == 3'd0) || (op_sel == 3'd1) || (op_sel == 3'd2) || (op_sel == 3'd4);

    // R2: test never writes the destination
    a_r2_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4) |-> !dst_we);

    // R4: carry and overflow low after a flag-writing op
    a_r4_cf_of_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flag_op) |=> (flags_q[2:1] == 2'b00));

    // R8: auxiliary carry kept across flag-writing ops
    a_r8_aux_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flag_op) |=> $stable(flags_q[0]));

    // R9: complement leaves every flag untouched
    a_r9_not_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd3) |=> $stable(flags_q));

    // R10: idle cycles hold flags and never write
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(flags_q));
    a_r10_idle_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !dst_we);

    // R11: byte mode passes the upper destination byte through
    a_r11_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> (result[WORD_W-1:BYTE_W] == dst_val[WORD_W-1:BYTE_W]));

    // R12: reset clears the flag file
    a_r12_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags_q == 6'd0));

    // R13: undefined codes do not write
    a_r13_undef_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 3'd4) |-> (!dst_we && result == dst_val));

endmodule

bind bitlogic_unit bitlogic_unit_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .byte_mode (byte_mode),
    .dst_val   (dst_val),
    .result    (result),
    .dst_we    (dst_we),
    .flags_q   (flags_q)
);

// File: tb/bitlogic_unit_tb.sv
`timescale 1ns/1ps
module bitlogic_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] dst_val = 16'd0;
    logic [15:0] src_val = 16'd0;
    logic [15:0] result;
    logic        dst_we;
    logic [5:0]  flags_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] res;
        logic        we;
        logic [5:0]  fl;
        logic [31:0] tag;
    } exp_t;

    exp_t        sbq[$];
    logic [5:0]  model_fl = 6'd0;

    always #2.5 clk = ~clk;

    bitlogic_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .byte_mode (byte_mode),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .result    (result),
        .dst_we    (dst_we),
        .flags_q   (flags_q)
    );

    task automatic chk(input logic [31:0] tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one operation at the falling edge and queues its expectation.
    task automatic drive(input logic [2:0] op, input logic bm, input logic [15:0] d,
                         input logic [15:0] s, input logic v);
        logic [15:0] full;
        exp_t e;
        @(negedge clk);
        in_valid = v; op_sel = op; byte_mode = bm; dst_val = d; src_val = s;
        case (op)
            3'd0, 3'd4: full = d & s;
            3'd1:       full = d | s;
            3'd2:       full = d ^ s;
            3'd3:       full = ~d;
            default:    full = d;
        endcase
        e.res = bm ? {d[15:8], full[7:0]} : full;
        e.we  = v && (op <= 3'd3);
        if (v && (op <= 3'd2 || op == 3'd4)) begin
            model_fl[5] = bm ? e.res[7] : e.res[15];
            model_fl[4] = bm ? (e.res[7:0] == 8'd0) : (e.res == 16'd0);
            model_fl[3] = ~^e.res[7:0];
            model_fl[2] = 1'b0;
            model_fl[1] = 1'b0;
        end
        e.fl = model_fl;
        if (!v)             e.tag = "R10";
        else if (op == 3'd4) e.tag = "R2";
        else if (op == 3'd3) e.tag = "R9";
        else if (op > 3'd4)  e.tag = "R13";
        else if (bm)         e.tag = "R11";
        else                 e.tag = "R1";
        sbq.push_back(e);
    endtask

    // Monitor: just after each rising edge, compares result, write-enable and flags.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, "result", result, e.res);
                chk(e.tag, "dst_we", {15'd0, dst_we}, {15'd0, e.we});
                chk(e.tag, "flags", {10'd0, flags_q}, {10'd0, e.fl});
            end
        end
    end

    task automatic drain();
        while (sbq.size() > 0) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "flags after reset", {10'd0, flags_q}, 16'd0);
        chk("R3", "dst_we idle", {15'd0, dst_we}, 16'd0);
        @(negedge clk); rst_n = 1'b1;

        drive(3'd0, 1'b1, 16'h00AA, 16'h00F0, 1'b1); // R1 R5 R7: 0xA0, sign 1, even parity
        drive(3'd1, 1'b0, 16'h00AA, 16'h00F0, 1'b1); // R5: word sign from bit 15 is 0
        drive(3'd2, 1'b0, 16'h5A5A, 16'h5A5A, 1'b1); // R6: XOR self gives zero flag
        drive(3'd1, 1'b0, 16'h1234, 16'h1234, 1'b1); // R6: OR self unchanged, zero 0
        drive(3'd1, 1'b0, 16'h0000, 16'h0000, 1'b1); // R6: OR of zero sets zero
        drive(3'd3, 1'b0, 16'h0F0F, 16'h0000, 1'b1); // R9: NOT writes but holds flags
        drive(3'd4, 1'b0, 16'h8001, 16'h8000, 1'b1); // R2 R4 R5: test, no write
        drive(3'd3, 1'b1, 16'hFF00, 16'h0000, 1'b1); // R9 R11: byte NOT keeps upper
        drive(3'd0, 1'b1, 16'hFF00, 16'hFF00, 1'b1); // R11 R6: upper ignored, zero 1
        drive(3'd2, 1'b1, 16'h0081, 16'h0000, 1'b1); // R7: two ones, even
        drive(3'd2, 1'b1, 16'h0001, 16'h0000, 1'b1); // R7: odd parity clears flag
        drive(3'd2, 1'b0, 16'hFFFF, 16'h0000, 1'b1); // R10 setup: flags non-zero
        drive(3'd2, 1'b0, 16'h0000, 16'h0000, 1'b0); // R10: invalid XOR holds flags
        drive(3'd0, 1'b0, 16'h0000, 16'h0000, 1'b0); // R3: no write without valid
        drive(3'd5, 1'b0, 16'hABCD, 16'h0000, 1'b1); // R13
        drive(3'd6, 1'b1, 16'h0000, 16'hFFFF, 1'b1); // R13
        drive(3'd7, 1'b0, 16'h8000, 16'h1111, 1'b1); // R13
        drive(3'd0, 1'b0, 16'hFFFF, 16'h00FF, 1'b1); // R8: aux stays 0

        for (int i = 0; i < 400; i++) begin
            drive(3'($urandom_range(0, 7)), 1'($urandom), 16'($urandom),
                  16'($urandom), ($urandom_range(0, 7) != 0));
        end
        drain();

        // R12: mid-run reset after flags were set
        drive(3'd2, 1'b0, 16'h1111, 16'h1111, 1'b1);
        drain();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R12", "flags after mid-run reset", {10'd0, flags_q}, 16'd0);
        model_fl = 6'd0;
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule